// File: doc/BRIEF.md
# Processor-Side Interrupt Signalling Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its single best candidate interrupt, an identifier and an 8-bit priority, where a smaller number means more urgent. The block compares that priority against a software-programmed threshold and against the priority of the interrupt now being serviced. It raises its request line to the processor only when the candidate is more urgent than both.

Software takes an interrupt by reading an acknowledge register. That read returns the identifier, tells the distributor to drop the pending state, marks the identifier active, and raises the running priority to the interrupt's priority. While the handler runs, candidates of equal or lower urgency are held back. Software retires the interrupt by writing its identifier to a separate end-of-interrupt register. That write clears the active mark, returns the running priority to idle, and tells the distributor the interrupt is finished.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, `irq_o` is low, the control register reads 0, the priority threshold reads 0x00, the running priority reads 0xFF, and no identifier is active.
- R2: While bit 0 of the control register (word address 0) is 0, `irq_o` is low. While it is 1, an eligible candidate drives `irq_o` high one clock after the candidate and configuration are in place. Only bit 0 is stored. The other bits read as 0.
- R3: A candidate is signalled only if its priority is numerically below the threshold register (word address 1, bits 7:0). A priority equal to the threshold is blocked. A threshold of 0xF0 passes a priority of 0xA0.
- R4: A candidate is signalled only if its priority is strictly below the running priority (word address 4, read-only, bits 7:0).
- R5: A read of word address 2 with an eligible candidate has these effects. The candidate identifier appears in `bus_rdata` bits 9:0 with `bus_rvalid` high one clock after the read. In that same cycle `ack_o` pulses with `ack_id_o` equal to the identifier, and the running priority takes the candidate's priority.
- R6: A read of word address 2 with no eligible candidate returns 1023. This covers no valid candidate, an insufficiently urgent candidate, or a disabled interface. In that case there is no `ack_o` pulse and the running priority does not change.
- R7: A write to word address 3 is a valid end-of-interrupt when bits 9:0 name an active identifier and all higher data bits are 0. One clock after such a write, `eoi_o` pulses with `eoi_id_o` equal to that identifier, the identifier stops being active, and the running priority reads 0xFF.
- R8: An end-of-interrupt write has no effect when it names an identifier that is not active or has any data bit above bit 9 set. It gives no `eoi_o` pulse and leaves the running priority unchanged.
- R9: A candidate with `cand_valid` low, or with an identifier not below NUM_IRQ, is never signalled and never acknowledged.
- R10: Reads of word addresses 5 to 7 return 0. Writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after a read |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate identifier |
| cand_prio | input | 8 | Candidate priority, smaller is more urgent |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Pulse: identifier taken, clear its pending state |
| ack_id_o | output | 10 | Identifier taken |
| eoi_o | output | 1 | Pulse: identifier retired |
| eoi_id_o | output | 10 | Identifier retired |

## Verification
Every result is registered once. `irq_o` follows a candidate or a configuration change one clock after the edge that captures it. Read data, `ack_o` and the new running priority appear one clock after the acknowledge read. `eoi_o` and the idle running priority appear one clock after the end-of-interrupt write. After an acknowledge, `irq_o` falls only a further clock later. The bench drives on falling edges and samples on the falling edge after the capturing rising edge. After any register write it waits one extra rising edge before it samples `irq_o`.

// File: rtl/cpu_irq_iface_pkg.sv
package cpu_irq_iface_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;

  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_THRESH = 3'd1,
    REG_TAKE  = 3'd2,
    REG_DONE  = 3'd3,
    REG_RUN   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } cand_t;
endpackage

// File: rtl/cpu_irq_iface_regs.sv
module cpu_irq_iface_regs
  import cpu_irq_iface_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              ctrl_en,
  output logic [PRIO_W-1:0] thresh,
  output logic              take_req,
  output logic              done_req,
  output logic [ID_W-1:0]   done_id
);
  logic hit_ctrl, hit_thresh, hit_take, hit_done;
  logic wr_ctrl, wr_thresh;
  logic ctrl_d;
  logic [PRIO_W-1:0] thresh_d;
  logic upper_clear;

  always_comb begin
    hit_ctrl   = (bus_addr == ADDR_W'(REG_CTRL));
    hit_thresh = (bus_addr == ADDR_W'(REG_THRESH));
    hit_take   = (bus_addr == ADDR_W'(REG_TAKE));
    hit_done   = (bus_addr == ADDR_W'(REG_DONE));
    wr_ctrl    = bus_en && bus_we && hit_ctrl;
    wr_thresh  = bus_en && bus_we && hit_thresh;
    // an identifier field with stray upper bits is treated as malformed
    upper_clear = (bus_wdata[DATA_W-1:ID_W] == '0);
    take_req   = bus_en && !bus_we && hit_take;
    done_req   = bus_en && bus_we && hit_done && upper_clear;
    done_id    = bus_wdata[ID_W-1:0];
  end

  always_comb begin
    ctrl_d   = ctrl_en;
    thresh_d = thresh;
    if (wr_ctrl)   ctrl_d   = bus_wdata[0];
    if (wr_thresh) thresh_d = bus_wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      thresh  <= '0;
    end else begin
      if (wr_ctrl)   ctrl_en <= ctrl_d;
      if (wr_thresh) thresh  <= thresh_d;
    end
  end
endmodule

// File: rtl/cpu_irq_iface_gate.sv
module cpu_irq_iface_gate
  import cpu_irq_iface_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cand_t             cand,
  input  logic              ctrl_en,
  input  logic [PRIO_W-1:0] thresh,
  input  logic [PRIO_W-1:0] run_prio,
  output logic              eligible,
  output logic              irq_q
);
  logic in_range, beats_thresh, beats_run;

  always_comb begin
    in_range     = (cand.id < ID_W'(NUM_IRQ));
    beats_thresh = (cand.prio < thresh);
    beats_run    = (cand.prio < run_prio);
    eligible     = ctrl_en && cand.valid && in_range && beats_thresh && beats_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= eligible;
  end
endmodule

// File: rtl/cpu_irq_iface_active.sv
module cpu_irq_iface_active
  import cpu_irq_iface_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cand_t             cand,
  input  logic              eligible,
  input  logic              take_req,
  input  logic              done_req,
  input  logic [ID_W-1:0]   done_id,
  output logic [PRIO_W-1:0] run_prio,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] act_q;
  logic               take_fire, done_fire, done_in_range;
  logic [IDX_W-1:0]   take_idx, done_idx;
  logic [PRIO_W-1:0]  run_d;

  always_comb begin
    take_idx      = cand.id[IDX_W-1:0];
    done_idx      = done_id[IDX_W-1:0];
    take_fire     = take_req && eligible;
    done_in_range = (done_id < ID_W'(NUM_IRQ));
    done_fire     = done_req && done_in_range && act_q[done_idx];
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_act
    logic set_i, clr_i;
    assign set_i = take_fire && (take_idx == IDX_W'(i));
    assign clr_i = done_fire && (done_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              act_q[i] <= 1'b0;
      else if (set_i || clr_i) act_q[i] <= set_i;
    end
  end

  always_comb begin
    run_d = run_prio;
    if (take_fire)      run_d = cand.prio;
    else if (done_fire) run_d = IDLE_PRIO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_prio <= IDLE_PRIO;
    else if (take_fire || done_fire) run_prio <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o    <= 1'b0;
      ack_id_o <= '0;
      eoi_o    <= 1'b0;
      eoi_id_o <= '0;
    end else begin
      ack_o <= take_fire;
      eoi_o <= done_fire;
      if (take_fire) ack_id_o <= cand.id;
      if (done_fire) eoi_id_o <= done_id;
    end
  end
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_iface_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  cand_t             cand;
  logic              ctrl_en, take_req, done_req, eligible, rd_req;
  logic [PRIO_W-1:0] thresh, run_prio;
  logic [ID_W-1:0]   done_id;
  logic [DATA_W-1:0] rdata_d;

  assign cand = '{valid: cand_valid, id: cand_id, prio: cand_prio};

  cpu_irq_iface_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl_en(ctrl_en),
    .thresh(thresh), .take_req(take_req), .done_req(done_req), .done_id(done_id)
  );

  cpu_irq_iface_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .clk(clk), .rst_n(rst_n), .cand(cand), .ctrl_en(ctrl_en),
    .thresh(thresh), .run_prio(run_prio), .eligible(eligible), .irq_q(irq_o)
  );

  cpu_irq_iface_active #(.NUM_IRQ(NUM_IRQ)) u_active (
    .clk(clk), .rst_n(rst_n), .cand(cand), .eligible(eligible),
    .take_req(take_req), .done_req(done_req), .done_id(done_id),
    .run_prio(run_prio), .ack_o(ack_o), .ack_id_o(ack_id_o),
    .eoi_o(eoi_o), .eoi_id_o(eoi_id_o)
  );

  always_comb begin
    rd_req  = bus_en && !bus_we;
    rdata_d = '0;
    case (bus_addr)
      ADDR_W'(REG_CTRL):   rdata_d[0] = ctrl_en;
      ADDR_W'(REG_THRESH): rdata_d[PRIO_W-1:0] = thresh;
      ADDR_W'(REG_TAKE):   rdata_d[ID_W-1:0] = eligible ? cand_id : SPURIOUS_ID;
      ADDR_W'(REG_RUN):    rdata_d[PRIO_W-1:0] = run_prio;
      default:             rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/cpu_irq_iface_chk.sv
module cpu_irq_iface_chk
  import cpu_irq_iface_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic [PRIO_W-1:0] thresh,
  input logic [PRIO_W-1:0] run_prio,
  input logic              cand_valid,
  input logic [PRIO_W-1:0] cand_prio,
  input logic              irq_o,
  input logic              ack_o,
  input logic              eoi_o,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] bus_rdata
);
  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !irq_o);

  assert_below_thresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cand_valid && (cand_prio < thresh)));

  assert_below_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cand_prio < run_prio));

  assert_take_raises_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (run_prio == $past(cand_prio)));

  assert_one_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, eoi_o}));

  assert_spurious_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && (bus_rdata == DATA_W'(SPURIOUS_ID))) |-> !ack_o);

  assert_done_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_o |-> (run_prio == IDLE_PRIO));

  assert_running_moves_only_on_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_o && !eoi_o) |-> $stable(run_prio));
endmodule

bind cpu_irq_iface cpu_irq_iface_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .thresh(thresh),
  .run_prio(run_prio), .cand_valid(cand_valid), .cand_prio(cand_prio),
  .irq_o(irq_o), .ack_o(ack_o), .eoi_o(eoi_o),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
);

// File: tb/cpu_irq_iface_test.sv
module cpu_irq_iface_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int NUM_IRQ = 64;
  localparam int WATCHDOG = 20000;

  localparam logic [2:0] A_CTRL = 3'd0, A_THR = 3'd1, A_TAKE = 3'd2,
                         A_DONE = 3'd3, A_RUN = 3'd4;

  // {enable, threshold, cand_valid, cand_prio, expected irq}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b1, 8'hF0, 1'b1, 8'hA0, 1'b1},
    {1'b1, 8'hA0, 1'b1, 8'hA0, 1'b0},
    {1'b1, 8'hA1, 1'b1, 8'hA0, 1'b1},
    {1'b0, 8'hF0, 1'b1, 8'hA0, 1'b0},
    {1'b1, 8'hF0, 1'b0, 8'h10, 1'b0},
    {1'b1, 8'h00, 1'b1, 8'h00, 1'b0},
    {1'b1, 8'hFF, 1'b1, 8'hFE, 1'b1},
    {1'b1, 8'hFF, 1'b1, 8'hFF, 1'b0}
  };

  logic clk, rst_n;
  logic bus_en, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic bus_rvalid;
  logic cand_valid;
  logic [9:0] cand_id;
  logic [7:0] cand_prio;
  logic irq_o, ack_o, eoi_o;
  logic [9:0] ack_id_o, eoi_id_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic done = 1'b0;

  cpu_irq_iface #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .irq_o(irq_o), .ack_o(ack_o), .ack_id_o(ack_id_o),
    .eoi_o(eoi_o), .eoi_id_o(eoi_id_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           output logic eoi_seen, output logic [9:0] eoi_id_seen);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    eoi_seen = eoi_o; eoi_id_seen = eoi_id_o;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                          output logic ack_seen, output logic [9:0] ack_id_seen);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    ack_seen = ack_o; ack_id_seen = ack_id_o;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [DATA_W-1:0] rd;
    logic hs;
    logic [9:0] hid;

    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cand_valid = 1'b0; cand_id = '0; cand_prio = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    bus_read(A_CTRL, rd, hs, hid); check("R1 ctrl", rd, 32'h0);
    bus_read(A_THR,  rd, hs, hid); check("R1 threshold", rd, 32'h0);
    bus_read(A_RUN,  rd, hs, hid); check("R1 running", rd, 32'hFF);
    bus_write(A_DONE, 32'd0, hs, hid); check("R1 no active id", {31'b0, hs}, 32'h0);

    // R2 R3 R4 eligibility table, running priority idle
    for (int i = 0; i < 8; i++) begin
      logic [18:0] v;
      v = VEC[i];
      @(negedge clk);
      cand_valid = v[9]; cand_prio = v[8:1]; cand_id = 10'd3;
      bus_write(A_CTRL, {31'b0, v[18]}, hs, hid);
      bus_write(A_THR, {24'b0, v[17:10]}, hs, hid);
      step();
      check($sformatf("R2/R3/R4 vector %0d irq", i), {31'b0, irq_o}, {31'b0, v[0]});
    end

    // R2 control keeps only bit 0
    bus_write(A_CTRL, 32'hFFFF_FFFF, hs, hid);
    bus_read(A_CTRL, rd, hs, hid); check("R2 ctrl readback", rd, 32'h1);

    // R9 out-of-range identifier
    bus_write(A_THR, 32'hF0, hs, hid);
    @(negedge clk); cand_valid = 1'b1; cand_id = 10'd100; cand_prio = 8'h10;
    step();
    check("R9 out-of-range irq", {31'b0, irq_o}, 32'h0);
    bus_read(A_TAKE, rd, hs, hid);
    check("R9 out-of-range take", rd, 32'd1023);
    check("R9 no ack", {31'b0, hs}, 32'h0);

    // R5 acknowledge
    @(negedge clk); cand_id = 10'd5; cand_prio = 8'h80;
    step();
    check("R5 irq before take", {31'b0, irq_o}, 32'h1);
    bus_read(A_TAKE, rd, hs, hid);
    check("R5 take id", rd, 32'd5);
    check("R5 ack pulse", {31'b0, hs}, 32'h1);
    check("R5 ack id", {22'b0, hid}, 32'd5);
    step();
    check("R4 equal priority blocked", {31'b0, irq_o}, 32'h0);
    bus_read(A_RUN, rd, hs, hid); check("R5 running", rd, 32'h80);
    check("R5 ack single pulse", {31'b0, ack_o}, 32'h0);

    // R4 more urgent than running, nested take
    @(negedge clk); cand_id = 10'd9; cand_prio = 8'h7F;
    step();
    check("R4 more urgent signalled", {31'b0, irq_o}, 32'h1);
    bus_read(A_TAKE, rd, hs, hid);
    check("R5 nested take id", rd, 32'd9);
    bus_read(A_RUN, rd, hs, hid); check("R5 nested running", rd, 32'h7F);

    // R8 ignored end-of-interrupt writes
    bus_write(A_DONE, 32'd7, hs, hid);
    check("R8 inactive id no pulse", {31'b0, hs}, 32'h0);
    bus_read(A_RUN, rd, hs, hid); check("R8 running kept", rd, 32'h7F);
    bus_write(A_DONE, 32'h0000_0405, hs, hid);
    check("R8 upper bits no pulse", {31'b0, hs}, 32'h0);
    bus_read(A_RUN, rd, hs, hid); check("R8 running kept upper", rd, 32'h7F);

    // R10 read-only write and unmapped reads
    bus_write(A_RUN, 32'h0, hs, hid);
    bus_read(A_RUN, rd, hs, hid); check("R10 read-only running", rd, 32'h7F);
    bus_read(3'd6, rd, hs, hid); check("R10 unmapped read", rd, 32'h0);

    // R7 valid end-of-interrupt
    @(negedge clk); cand_valid = 1'b0;
    bus_write(A_DONE, 32'd5, hs, hid);
    check("R7 eoi pulse", {31'b0, hs}, 32'h1);
    check("R7 eoi id", {22'b0, hid}, 32'd5);
    bus_read(A_RUN, rd, hs, hid); check("R7 running idle", rd, 32'hFF);
    bus_write(A_DONE, 32'd5, hs, hid);
    check("R8 repeated eoi ignored", {31'b0, hs}, 32'h0);
    bus_write(A_DONE, 32'd9, hs, hid);
    check("R7 second eoi pulse", {31'b0, hs}, 32'h1);
    check("R7 second eoi id", {22'b0, hid}, 32'd9);

    // R6 spurious acknowledge
    bus_read(A_TAKE, rd, hs, hid);
    check("R6 no candidate id", rd, 32'd1023);
    check("R6 no ack", {31'b0, hs}, 32'h0);
    @(negedge clk); cand_valid = 1'b1; cand_id = 10'd12; cand_prio = 8'hF5;
    bus_read(A_TAKE, rd, hs, hid);
    check("R6 above threshold id", rd, 32'd1023);
    bus_write(A_CTRL, 32'h0, hs, hid);
    @(negedge clk); cand_prio = 8'h10;
    bus_read(A_TAKE, rd, hs, hid);
    check("R6 disabled id", rd, 32'd1023);
    check("R6 disabled no ack", {31'b0, hs}, 32'h0);
    bus_read(A_RUN, rd, hs, hid); check("R6 running unchanged", rd, 32'hFF);
    check("R2 disabled irq low", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule